// File: doc/BRIEF.md
# Auto-Reload Event Divider

This block divides an asynchronous event stream by a ratio that software can change while it runs. Each rising edge of `evt_in` counts as one event. The edge is passed through a two-flop synchroniser into the system clock domain, and a registered previous-value flop detects it. A 4-bit working counter steps down by one on each event. An event that arrives while the counter is at zero does two things: it copies the 4-bit reload register into the counter, and it raises `tc_pulse` for one system-clock cycle.

The reload register sits apart from the working counter. A processor writes it through a one-cycle strobe, `wr_en`, with data on `wr_data`. The counter picks up a new value only at its next automatic reload, so the count already in progress finishes with the old ratio. A reload value N gives one pulse every N+1 events, and zero gives divide-by-one.

The counting control is a two-state machine:
- **ST_ARMED**: the counter holds zero, and the next event fires.
- **ST_RUN**: the counter holds a nonzero value.

Its transitions are:
- **ARMED→ARMED (fire, reload zero)**
- **ARMED→RUN (fire, reload nonzero)**
- **RUN→RUN (step, count above one)**
- **RUN→ARMED (step, count equals one)**

Top module: `evt_divider`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the reload register, the working counter, the synchroniser and edge flops, and `tc_pulse` to zero.
- R2: A clock edge with `wr_en` high stores `wr_data` into the reload register.
- R3: `evt_in` passes through two synchroniser flops. An event is a 0-to-1 transition of the synchronised signal. `tc_pulse` for an event is high in the cycle that follows the third clock edge counted from the first edge that samples `evt_in` high.
- R4: An event with a nonzero working count lowers the count by exactly one and leaves `tc_pulse` low.
- R5: An event with a working count of zero loads the reload register into the counter and raises `tc_pulse`.
- R6: `tc_pulse` is high for exactly one clock cycle per terminal-count event.
- R7: A reload write does not change the count in progress. The new value is first used at the next reload. A write in the same cycle as a reload takes effect only at the reload after that one.
- R8: With reload value N held steady, `tc_pulse` fires once every N+1 events. N = 0 fires on every event, and N = 15 fires once every 16 events.
- R9: Holding `evt_in` high counts as one event only. The counter does not move without a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Reload-register write strobe |
| wr_data | input | 4 | Reload value to write |
| evt_in | input | 1 | Asynchronous event input |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |

## Verification
A reload write is visible one edge after the strobe. A terminal-count pulse shows up after three edges: two synchroniser flops and the registered pulse flop, counted from the first edge that samples `evt_in` high. The bench drives `evt_in` on a falling edge and samples `tc_pulse` on the third falling edge after that. It samples again one cycle later to confirm the pulse has dropped. Writes are placed a full cycle before the event that should see them, so each expected pulse pattern follows directly from the reload arithmetic.

// File: rtl/evt_div_pkg.sv
package evt_div_pkg;
    parameter int CNT_W       = 4;
    parameter int SYNC_STAGES = 2;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [0:0] {
        ST_ARMED = 1'b0,
        ST_RUN   = 1'b1
    } div_state_e;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/rise_detect.sv
module rise_detect (
    input  logic clk,
    input  logic rst,
    input  logic level_in,
    output logic rise_out
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level_in;
    end

    assign rise_out = level_in & ~prev_q;
endmodule

// File: rtl/div_fsm.sv
module div_fsm
    import evt_div_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] count,
    output div_state_e   state,
    output logic         tc_out
);
    localparam logic [W-1:0] ONE = W'(1);

    div_state_e   state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic         fire;
    logic         tc_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fire    = 1'b0;
        if (step) begin
            unique case (state_q)
                ST_ARMED: begin
                    fire    = 1'b1;
                    cnt_d   = reload_val;
                    state_d = (reload_val == '0) ? ST_ARMED : ST_RUN;
                end
                ST_RUN: begin
                    cnt_d   = cnt_q - ONE;
                    state_d = (cnt_q == ONE) ? ST_ARMED : ST_RUN;
                end
                default: begin
                    state_d = ST_ARMED;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ARMED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) tc_q <= 1'b0;
        else     tc_q <= fire;
    end

    assign count  = cnt_q;
    assign state  = state_q;
    assign tc_out = tc_q;
endmodule

// File: rtl/evt_divider.sv
module evt_divider
    import evt_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             evt_in,
    output logic             tc_pulse
);
    logic       evt_sync_lvl;
    logic       evt_edge;
    cnt_t       reload_q;
    cnt_t       work_cnt;
    div_state_e fsm_state;

    always_ff @(posedge clk) begin
        if (rst)        reload_q <= '0;
        else if (wr_en) reload_q <= wr_data;
    end

    evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (evt_in),
        .sync_out (evt_sync_lvl)
    );

    rise_detect u_rise (
        .clk      (clk),
        .rst      (rst),
        .level_in (evt_sync_lvl),
        .rise_out (evt_edge)
    );

    div_fsm #(.W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .step       (evt_edge),
        .reload_val (reload_q),
        .count      (work_cnt),
        .state      (fsm_state),
        .tc_out     (tc_pulse)
    );
endmodule

// File: rtl/evt_divider_chk.sv
module evt_divider_chk
    import evt_div_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input cnt_t       wr_data,
    input logic       tc_pulse,
    input logic       evt_edge,
    input cnt_t       reload_q,
    input cnt_t       work_cnt,
    input div_state_e fsm_state
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (tc_pulse == 1'b0 && work_cnt == '0 && reload_q == '0));

    // R2
    reload_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> reload_q == $past(wr_data));

    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_edge && work_cnt != '0) |=> (work_cnt == CNT_W'($past(work_cnt) - 1'b1) && !tc_pulse));

    // R5
    term_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_edge && work_cnt == '0) |=> (work_cnt == $past(reload_q) && tc_pulse));

    // R6
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        tc_pulse |=> !tc_pulse);

    // R9
    hold_count_chk: assert property (@(posedge clk) disable iff (rst)
        !evt_edge |=> $stable(work_cnt));

    // R5
    armed_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (fsm_state == ST_ARMED) == (work_cnt == '0));
endmodule

bind evt_divider evt_divider_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .tc_pulse  (tc_pulse),
    .evt_edge  (evt_edge),
    .reload_q  (reload_q),
    .work_cnt  (work_cnt),
    .fsm_state (fsm_state)
);

// File: tb/test_evt_divider.sv
`timescale 1ns/1ps
module test_evt_divider;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = 4'd0;
    logic       evt_in = 1'b0;
    logic       tc_pulse;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    evt_divider i_evt_divider (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .evt_in   (evt_in),
        .tc_pulse (tc_pulse)
    );

    // {do_write, data[3:0], expected pulse}
    localparam int NV = 14;
    localparam logic [5:0] VEC [NV] = '{
        {1'b1, 4'd2,  1'b1},  // R5 fire from zero, load 2
        {1'b0, 4'd0,  1'b0},  // R4 2->1
        {1'b0, 4'd0,  1'b0},  // R4 1->0
        {1'b1, 4'd0,  1'b1},  // R5 fire, load 0
        {1'b0, 4'd0,  1'b1},  // R8 divide-by-one
        {1'b1, 4'd3,  1'b1},  // R5 fire, load 3
        {1'b1, 4'd1,  1'b0},  // R7 write mid-count, 3->2
        {1'b0, 4'd0,  1'b0},  // R7 2->1
        {1'b0, 4'd0,  1'b0},  // R7 1->0
        {1'b0, 4'd0,  1'b1},  // R7 fire, load new 1
        {1'b0, 4'd0,  1'b0},  // R8 1->0
        {1'b0, 4'd0,  1'b1},  // R8 fire, load 1
        {1'b1, 4'd15, 1'b0},  // R7 1->0
        {1'b0, 4'd0,  1'b1}   // R5 fire, load 15
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: tc_pulse actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // rising event; pulse due after three edges, then must drop
    task automatic do_event(input string req, input logic exp);
        @(negedge clk);
        evt_in = 1'b1;
        repeat (2) begin
            @(negedge clk);
            check({req, " early"}, tc_pulse, 1'b0);  // R3 not before third edge
        end
        @(negedge clk);
        check(req, tc_pulse, exp);
        evt_in = 1'b0;
        @(negedge clk);
        check({req, " width"}, tc_pulse, 1'b0);      // R6
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset", tc_pulse, 1'b0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][5]) do_write(VEC[i][4:1]);
            do_event($sformatf("vec%0d R4/R5/R7/R8", i), VEC[i][0]);
        end

        // R8: reload 15 loaded by last vector -> 15 silent events, then fire
        for (int i = 0; i < 15; i++) do_event("R8 div16 silent", 1'b0);
        do_event("R8 div16 fire", 1'b1);

        // R9: held high input counts once
        do_write(4'd1);
        do_event("R9 pre", 1'b0);        // 15->14
        @(negedge clk);
        evt_in = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            check("R9 held high", tc_pulse, 1'b0);
        end
        evt_in = 1'b0;
        for (int i = 0; i < 13; i++) do_event("R9 remaining", 1'b0);  // 13..1 -> 0
        do_event("R9 fire after held", 1'b1);

        // R1: reset mid-count clears count and reload
        do_write(4'd9);
        do_event("R1 pre", 1'b0);        // 1->0
        do_event("R1 pre fire", 1'b1);   // load 9
        do_event("R1 pre step", 1'b0);   // 9->8
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid-count", tc_pulse, 1'b0);
        rst = 1'b0;
        do_event("R1 count cleared", 1'b1);
        do_event("R1 reload cleared", 1'b1);

        // R2: write while armed is used at this reload
        do_write(4'd2);
        do_event("R2 fire load 2", 1'b1);
        do_event("R2 2->1", 1'b0);
        do_event("R2 1->0", 1'b0);
        do_event("R2 fire again", 1'b1);

        finish_run();
    end
endmodule